// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative address translation cache. Every slot describes two neighbouring virtual pages at once: an even page and an odd page. Each page has its own frame base, its own valid bit and its own dirty (writable) bit. A per-slot page mask sets the page size, and a per-slot global flag lets the slot match under any address-space identifier.

A lookup presents a 32-bit virtual address, a read/write flag and the current 8-bit address-space identifier. One cycle later the block returns a physical address, a read/write permission pair and a 3-bit result code. The code tells a successful translation apart from three failures: a miss, an invalid page and a write to a clean page. The miss case is what a refill handler acts on. A separate write port loads a complete slot at a chosen index, for example from a refill handler.

Top module: `pagepair_tlb`

## Requirements
- R1: After reset no slot is loaded, so every lookup returns code 3'b110 until a slot is written. Right after reset the outputs are: rspValid 0, rspCode 3'b110, rspPhys 0, and both permissions 0.
- R2: rspValid is high in exactly the cycle after a clock edge that samples reqValid high, and low otherwise. A lookup sees slot contents as they were before a write on the same edge.
- R3: A slot hits when it is loaded, when its global flag is set or its stored identifier equals curAsid, and when the address equals its stored page-pair number after both have the effective-mask bits cleared. The effective mask is the slot's page mask ORed with 32'h0000_1FFF.
- R4: The address bit at the highest set position of the effective mask picks the half: 0 picks the even page, 1 picks the odd page. This is bit 12 for a zero page mask and bit 14 for a page mask of 32'h0000_6000.
- R5: If the picked half is not valid, the code is 3'b101 (invalid). This holds for reads and for writes.
- R6: A write to a valid half whose dirty bit is clear returns code 3'b100 (modify). A read of the same half returns 3'b000.
- R7: On code 3'b000, rspPhys equals the picked frame base ORed with the address bits under the effective mask shifted right by one. rspRead is 1, and rspWrite equals the picked dirty bit.
- R8: With no hit the code is 3'b110. For any code other than 3'b000, rspPhys is 0 and both permissions are 0. Code 3'b111 (bad address) is reserved and never produced.
- R9: When several slots hit, the lowest-index slot alone decides the result.
- R10: A write-port strobe stores all fields at wrIdx and replaces what was there before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Load a slot |
| wrIdx | input | 4 | Slot index to load |
| wrVpn | input | 32 | Virtual page-pair address (bits under the mask are ignored) |
| wrPageMask | input | 32 | Page-size mask, contiguous ones starting at bit 13 |
| wrAsid | input | 8 | Address-space identifier of the slot |
| wrGlobal | input | 1 | Match under any identifier |
| wrPfnEven | input | 32 | Frame base of the even page |
| wrPfnOdd | input | 32 | Frame base of the odd page |
| wrValidEven | input | 1 | Even page valid |
| wrValidOdd | input | 1 | Odd page valid |
| wrDirtyEven | input | 1 | Even page writable |
| wrDirtyOdd | input | 1 | Odd page writable |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 for a store access, 0 for a load access |
| curAsid | input | 8 | Current address-space identifier |
| rspValid | output | 1 | Result valid |
| rspPhys | output | 32 | Translated physical address |
| rspRead | output | 1 | Read permitted |
| rspWrite | output | 1 | Write permitted |
| rspCode | output | 3 | Result code: 000 match, 110 miss, 101 invalid, 100 modify |

## Verification
The bench targets the following corner cases.

- **Half selection with a large page.** It uses 16 KB pages, where the half-select bit moves from bit 12 to bit 14. A design with a fixed select bit would read the wrong half and return a wrong frame or a wrong invalid code.
- **Global flag and identifier match.** It checks the global flag against a foreign identifier, and two slots that differ only in identifier. A design that ignores either rule would produce spurious hits or spurious misses.
- **Overlapping slots.** It overwrites slot 0 with an invalid even half while slot 5 still maps the same page. Choosing a valid higher slot there would return 3'b000 in place of 3'b101.
- **Write and lookup on the same edge.** A lookup issued on the same edge as a write to its slot must see the old contents.
- **Unloaded slots after reset.** A lookup of address 0 under identifier 0 after reset must miss. A design without a loaded flag would hit a cleared slot there.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int TLB_ADDR_W = 32;
  localparam int TLB_ASID_W = 8;
  localparam int TLB_PAIR_LSB = 13;  // first bit of the page-pair number for the smallest page

  typedef enum logic [2:0] {
    RES_MATCH   = 3'b000,
    RES_BADADDR = 3'b111,
    RES_NOMATCH = 3'b110,
    RES_INVALID = 3'b101,
    RES_DIRTY   = 3'b100
  } tlbRes_t;

  typedef struct packed {
    logic                  loaded;
    logic                  glob;
    logic [TLB_ASID_W-1:0] asid;
    logic [TLB_ADDR_W-1:0] vpn;
    logic [TLB_ADDR_W-1:0] pageMask;
    logic [TLB_ADDR_W-1:0] pfnEven;
    logic [TLB_ADDR_W-1:0] pfnOdd;
    logic                  validEven;
    logic                  validOdd;
    logic                  dirtyEven;
    logic                  dirtyOdd;
  } tlbEntry_t;

  typedef struct packed {
    logic load;      // capture a response this cycle
    logic passPhys;  // result is a match: forward address and read grant
    logic grantWr;   // result is a match on a dirty half
  } tlbStb_t;

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = TLB_ADDR_W,
  parameter int ASID_W  = TLB_ASID_W,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  tlbEntry_t         wrEntry,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ASID_W-1:0] curAsid,
  input  tlbStb_t           stb,
  output logic              hitAny,
  output logic              selValid,
  output logic              selDirty,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspRead,
  output logic              rspWrite
);

  localparam logic [ADDR_W-1:0] LOW_MASK = {ADDR_W{1'b1}} >> (ADDR_W - TLB_PAIR_LSB);

  tlbEntry_t         slots [ENTRIES];
  logic [ENTRIES-1:0] hitVec;
  logic [ADDR_W-1:0]  effMask [ENTRIES];
  logic [IDX_W-1:0]   winIdx;
  logic [ADDR_W-1:0]  winMask;
  logic               oddSel;
  logic [ADDR_W-1:0]  physComb;
  tlbEntry_t          winSlot;

  // slot storage and write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
    end else if (wrEn && (int'(wrIdx) < ENTRIES)) begin
      slots[wrIdx] <= wrEntry;
    end
  end

  // per-slot compare
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    logic asidOk;
    logic tagOk;
    assign effMask[g] = slots[g].pageMask | LOW_MASK;
    assign asidOk     = slots[g].glob || (slots[g].asid == curAsid);
    assign tagOk      = (reqAddr & ~effMask[g]) == (slots[g].vpn & ~effMask[g]);
    assign hitVec[g]  = slots[g].loaded && asidOk && tagOk;
  end

  // lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) winIdx = IDX_W'(i);
    end
  end

  assign hitAny  = |hitVec;
  assign winSlot = slots[winIdx];
  assign winMask = effMask[winIdx];
  assign oddSel  = |(reqAddr & winMask & ~(winMask >> 1));

  always_comb begin
    if (oddSel) begin
      selValid = winSlot.validOdd;
      selDirty = winSlot.dirtyOdd;
      physComb = winSlot.pfnOdd | (reqAddr & (winMask >> 1));
    end else begin
      selValid = winSlot.validEven;
      selDirty = winSlot.dirtyEven;
      physComb = winSlot.pfnEven | (reqAddr & (winMask >> 1));
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspPhys  <= '0;
      rspRead  <= 1'b0;
      rspWrite <= 1'b0;
    end else if (stb.load) begin
      rspPhys  <= stb.passPhys ? physComb : '0;
      rspRead  <= stb.passPhys;
      rspWrite <= stb.grantWr;
    end
  end

  AST_WRITE_IMPLIES_READ: assert property (@(posedge clk) disable iff (!rstN)
    rspWrite |-> rspRead);  // R7
  AST_DENIED_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rspRead |-> (rspPhys == '0));  // R8

endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    hitAny,
  input  logic    selValid,
  input  logic    selDirty,
  output tlbStb_t stb,
  output logic    rspValid,
  output tlbRes_t rspCode
);

  tlbRes_t codeNext;

  always_comb begin
    if (!hitAny)                    codeNext = RES_NOMATCH;
    else if (!selValid)             codeNext = RES_INVALID;
    else if (reqWrite && !selDirty) codeNext = RES_DIRTY;
    else                            codeNext = RES_MATCH;
  end

  always_comb begin
    stb.load     = reqValid;
    stb.passPhys = (codeNext == RES_MATCH);
    stb.grantWr  = (codeNext == RES_MATCH) && selDirty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode  <= RES_NOMATCH;
    end else begin
      rspValid <= reqValid;
      if (reqValid) rspCode <= codeNext;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);  // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);  // R2
  AST_READ_NEVER_MODIFY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> (rspCode != RES_DIRTY));  // R6
  AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !hitAny) |=> (rspCode == RES_NOMATCH));  // R8
  AST_NO_BADADDR: assert property (@(posedge clk) disable iff (!rstN)
    rspCode != RES_BADADDR);  // R8
  AST_INVALID_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && hitAny && !selValid) |=> (rspCode == RES_INVALID));  // R5

endmodule

// File: rtl/pagepair_tlb.sv
module pagepair_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = TLB_ADDR_W,
  parameter int ASID_W  = TLB_ASID_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrVpn,
  input  logic [ADDR_W-1:0] wrPageMask,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [ADDR_W-1:0] wrPfnEven,
  input  logic [ADDR_W-1:0] wrPfnOdd,
  input  logic              wrValidEven,
  input  logic              wrValidOdd,
  input  logic              wrDirtyEven,
  input  logic              wrDirtyOdd,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [ASID_W-1:0] curAsid,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspRead,
  output logic              rspWrite,
  output logic [2:0]        rspCode
);

  tlbEntry_t wrEntry;
  tlbStb_t   stb;
  tlbRes_t   codeReg;
  logic      hitAny;
  logic      selValid;
  logic      selDirty;

  always_comb begin
    wrEntry.loaded    = 1'b1;
    wrEntry.glob      = wrGlobal;
    wrEntry.asid      = wrAsid;
    wrEntry.vpn       = wrVpn;
    wrEntry.pageMask  = wrPageMask;
    wrEntry.pfnEven   = wrPfnEven;
    wrEntry.pfnOdd    = wrPfnOdd;
    wrEntry.validEven = wrValidEven;
    wrEntry.validOdd  = wrValidOdd;
    wrEntry.dirtyEven = wrDirtyEven;
    wrEntry.dirtyOdd  = wrDirtyOdd;
  end

  tlb_datapath #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrEntry(wrEntry),
    .reqAddr(reqAddr), .curAsid(curAsid), .stb(stb),
    .hitAny(hitAny), .selValid(selValid), .selDirty(selDirty),
    .rspPhys(rspPhys), .rspRead(rspRead), .rspWrite(rspWrite)
  );

  tlb_control i_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .hitAny(hitAny), .selValid(selValid), .selDirty(selDirty),
    .stb(stb), .rspValid(rspValid), .rspCode(codeReg)
  );

  assign rspCode = codeReg;

  AST_MATCH_GRANTS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspCode == 3'b000)) |-> rspRead);  // R7
  AST_FAIL_DENIES_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspCode != 3'b000)) |-> (!rspRead && !rspWrite));  // R8

endmodule

// File: tb/test_pagepair_tlb.sv
`timescale 1ns/1ps
module test_pagepair_tlb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrVpn = '0, wrPageMask = '0, wrPfnEven = '0, wrPfnOdd = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0, wrValidEven = 1'b0, wrValidOdd = 1'b0;
  logic        wrDirtyEven = 1'b0, wrDirtyOdd = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [7:0]  curAsid = '0;
  logic        rspValid, rspRead, rspWrite;
  logic [31:0] rspPhys;
  logic [2:0]  rspCode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pagepair_tlb i_pagepair_tlb (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrVpn(wrVpn),
    .wrPageMask(wrPageMask), .wrAsid(wrAsid), .wrGlobal(wrGlobal),
    .wrPfnEven(wrPfnEven), .wrPfnOdd(wrPfnOdd), .wrValidEven(wrValidEven),
    .wrValidOdd(wrValidOdd), .wrDirtyEven(wrDirtyEven), .wrDirtyOdd(wrDirtyOdd),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .curAsid(curAsid),
    .rspValid(rspValid), .rspPhys(rspPhys), .rspRead(rspRead), .rspWrite(rspWrite),
    .rspCode(rspCode)
  );

  // {addr[31:0], write, asid[7:0], code[2:0], phys[31:0], read, writePerm}
  localparam int NV = 13;
  localparam logic [77:0] VECS [NV] = '{
    {32'h0040_0123, 1'b0, 8'h11, 3'b000, 32'h0A00_0123, 1'b1, 1'b1},  // R3 R7 even
    {32'h0040_0123, 1'b1, 8'h11, 3'b000, 32'h0A00_0123, 1'b1, 1'b1},  // R7 write dirty
    {32'h0040_1ABC, 1'b0, 8'h11, 3'b000, 32'h0B00_0ABC, 1'b1, 1'b0},  // R4 R6 odd read clean
    {32'h0040_1ABC, 1'b1, 8'h11, 3'b100, 32'h0000_0000, 1'b0, 1'b0},  // R6 modify
    {32'h0040_0010, 1'b0, 8'h22, 3'b000, 32'h0C00_0010, 1'b1, 1'b1},  // R3 other asid
    {32'h0040_0010, 1'b0, 8'h33, 3'b110, 32'h0000_0000, 1'b0, 1'b0},  // R3 R8 asid miss
    {32'h0080_1234, 1'b0, 8'h77, 3'b101, 32'h0000_0000, 1'b0, 1'b0},  // R4 R5 global, even invalid
    {32'h0080_1234, 1'b1, 8'h77, 3'b101, 32'h0000_0000, 1'b0, 1'b0},  // R5 write invalid
    {32'h0080_5678, 1'b0, 8'h77, 3'b000, 32'h0300_1678, 1'b1, 1'b1},  // R4 bit14 odd
    {32'h0080_7FFF, 1'b1, 8'h00, 3'b000, 32'h0300_3FFF, 1'b1, 1'b1},  // R7 top of page
    {32'h0081_0000, 1'b0, 8'h77, 3'b110, 32'h0000_0000, 1'b0, 1'b0},  // R3 tag bit16
    {32'h0040_2000, 1'b0, 8'h11, 3'b110, 32'h0000_0000, 1'b0, 1'b0},  // R3 tag bit13
    {32'h8000_0000, 1'b0, 8'h11, 3'b110, 32'h0000_0000, 1'b0, 1'b0}   // R8 miss
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic loadEntry(input logic [3:0] idx, input logic [31:0] vpn, input logic [31:0] msk,
                           input logic [7:0] asid, input logic g, input logic [31:0] pe,
                           input logic [31:0] po, input logic ve, input logic vo,
                           input logic de, input logic dd);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrVpn = vpn; wrPageMask = msk; wrAsid = asid; wrGlobal = g;
    wrPfnEven = pe; wrPfnOdd = po; wrValidEven = ve; wrValidOdd = vo;
    wrDirtyEven = de; wrDirtyOdd = dd;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic w, input logic [7:0] asid);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = w; curAsid = asid;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectRsp(input string req, input logic [2:0] code, input logic [31:0] phys,
                           input logic r, input logic w);
    check({req, " valid"}, {31'd0, rspValid}, 32'd1);
    check({req, " code"}, {29'd0, rspCode}, {29'd0, code});
    check({req, " phys"}, rspPhys, phys);
    check({req, " perm"}, {30'd0, rspRead, rspWrite}, {30'd0, r, w});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 rspValid", {31'd0, rspValid}, 32'd0);
    check("R1 code", {29'd0, rspCode}, 32'd6);
    check("R1 phys", rspPhys, 32'd0);
    check("R1 perm", {30'd0, rspRead, rspWrite}, 32'd0);
    lookup(32'h0000_0000, 1'b0, 8'h00);
    expectRsp("R1 empty lookup", 3'b110, 32'd0, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 idle after response", {31'd0, rspValid}, 32'd0);

    loadEntry(4'd0, 32'h0040_0000, 32'h0, 8'h11, 1'b0, 32'h0A00_0000, 32'h0B00_0000, 1, 1, 1, 0);
    loadEntry(4'd1, 32'h0080_0000, 32'h6000, 8'h00, 1'b1, 32'h0200_0000, 32'h0300_0000, 0, 1, 0, 1);
    loadEntry(4'd2, 32'h0040_0000, 32'h0, 8'h22, 1'b0, 32'h0C00_0000, 32'h0D00_0000, 1, 1, 1, 1);
    loadEntry(4'd5, 32'h0040_0000, 32'h0, 8'h11, 1'b0, 32'h0E00_0000, 32'h0E00_1000, 1, 1, 1, 1);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i][77:46], VECS[i][45], VECS[i][44:37]);
      expectRsp($sformatf("R3 R9 vec%0d", i), VECS[i][36:34], VECS[i][33:2],
                VECS[i][1], VECS[i][0]);
    end

    // R2: same-edge write and lookup sees old contents
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 4'd7; wrVpn = 32'h0100_0000; wrPageMask = 32'h0; wrAsid = 8'h00;
    wrGlobal = 1'b1; wrPfnEven = 32'h0F00_0000; wrPfnOdd = 32'h0; wrValidEven = 1'b1;
    wrValidOdd = 1'b0; wrDirtyEven = 1'b1; wrDirtyOdd = 1'b0;
    reqValid = 1'b1; reqAddr = 32'h0100_0004; reqWrite = 1'b0; curAsid = 8'h44;
    @(negedge clk);
    wrEn = 1'b0; reqValid = 1'b0;
    expectRsp("R2 same-edge", 3'b110, 32'd0, 1'b0, 1'b0);
    lookup(32'h0100_0004, 1'b0, 8'h44);
    expectRsp("R10 new slot", 3'b000, 32'h0F00_0004, 1'b1, 1'b1);

    // R10 + R9: overwrite slot 0 with invalid even half while slot 5 still maps it
    loadEntry(4'd0, 32'h0040_0000, 32'h0, 8'h11, 1'b0, 32'h0A00_0000, 32'h0B00_0000, 0, 1, 0, 1);
    lookup(32'h0040_0123, 1'b0, 8'h11);
    expectRsp("R9 R10 overwrite", 3'b101, 32'd0, 1'b0, 1'b0);
    lookup(32'h0040_1004, 1'b1, 8'h11);
    expectRsp("R10 odd now dirty", 3'b000, 32'h0B00_0004, 1'b1, 1'b1);

    // R1: reset clears slots
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 rspValid after reset", {31'd0, rspValid}, 32'd0);
    check("R1 code after reset", {29'd0, rspCode}, 32'd6);
    lookup(32'h0080_5678, 1'b0, 8'h77);
    expectRsp("R1 cleared", 3'b110, 32'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule